// File: doc/BRIEF.md
# Clock Source Switch Controller

This block decides which of two clock sources paces the CPU. Both sources reach it as one-cycle tick strobes in a single fabric clock: a slow internal oscillator that is always available, and a fast high-speed oscillator that needs a long settling period. After reset the CPU runs from the internal source. It receives its first tick only after a fixed number of internal ticks have gone by.

A settling counter counts high-speed ticks while that oscillator is enabled. Software can read its progress as five threshold flags, and it picks which threshold must be reached. A request to move to the high-speed source is held pending until the chosen threshold has been reached. The change then happens on a cycle where neither tick strobe is active, and a status bit reports the active source. The block also gates the two oscillator enables during reset and during stop mode. It refuses to stop the oscillator that is currently driving the CPU.

Top module: `clk_src_switch`

## Requirements
- R1: While rstN is low, hsOscEn and intOscEn are 0 and cpuTick is 0. After reset, srcIsHs is 0, stabFlags is 0 and both enables are 1.
- R2: After reset is released, the first 17 internal ticks produce no cpuTick. From the 18th internal tick on, cpuTick follows intTick while the internal source is active.
- R3: stabFlags bit k is 1 once the settling counter has counted at least 2^E high-speed ticks, with E = 11, 13, 14, 15, 16 for k = 0..4. The counter advances only while hsOscEn is 1.
- R4: A write to address 1 loads the threshold code from wrData[2:0]. Code c in 0..4 selects stabFlags bit c, and codes 5, 6 and 7 act as code 4. The reset code is 0.
- R5: A write to address 0 loads wrData[0] as the source request (1 = high-speed). While the selected flag is 0, the request stays pending: srcIsHs stays 0 and cpuTick keeps following intTick.
- R6: srcIsHs changes only at a clock edge where intTick and hsTick were both 0. Once srcIsHs is 1, cpuTick follows hsTick and ignores intTick.
- R7: With the request at 0 and the internal oscillator enabled, srcIsHs returns to 0 on the next idle edge. While the internal oscillator is stopped, the return is held.
- R8: At address 0, wrData[1]=1 stops the high-speed oscillator and wrData[2]=1 stops the internal one, and a 0 in either bit restarts that oscillator. Stopping the high-speed oscillator is ignored while srcIsHs is 1, and stopping the internal one is ignored while srcIsHs is 0. Stopping the high-speed oscillator clears the counter and all flags.
- R9: A stopEnter pulse drops both enables and blocks cpuTick until a stopRelease pulse. After release on the high-speed source, cpuTick stays 0 until the selected threshold is reached again. After release on the internal source, cpuTick resumes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Synchronous reset, active low |
| intTick | input | 1 | Internal oscillator tick strobe |
| hsTick | input | 1 | High-speed oscillator tick strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Register address: 0 control, 1 threshold code |
| wrData | input | 3 | Register write data |
| stopEnter | input | 1 | Enter stop mode (pulse) |
| stopRelease | input | 1 | Leave stop mode (pulse) |
| cpuTick | output | 1 | Tick strobe delivered to the CPU |
| srcIsHs | output | 1 | 1 when the high-speed source drives the CPU |
| stabFlags | output | 5 | Settling progress, one flag per threshold |
| hsOscEn | output | 1 | High-speed oscillator enable |
| intOscEn | output | 1 | Internal oscillator enable |

## Verification
The switch is tried three ways: with alternating internal and high-speed ticks, with an unbroken run of high-speed ticks, and with idle cycles placed just before and just after the threshold is reached. These patterns separate "pending" from "switched" and show that a busy cycle delays the change. The threshold code is tried at 0 and at the out-of-range value 7. At code 7, an idle cycle after the 2^15 flag has set must not switch, which tells the clamp apart from a plain bit decode. Stop release is driven on both sources, which shows that settling is re-run only on the high-speed path. Illegal oscillator stops are tried while each source is active, and the enables are observed directly.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int NUM_STAB = 5;
  localparam int SEL_W    = $clog2(NUM_STAB);
  localparam int DATA_W   = 3;

  typedef struct packed {
    logic hsRun;
    logic intRun;
    logic useHs;
    logic cpuHold;
  } ctrlStrobe_t;
endpackage

// File: rtl/clksw_datapath.sv
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int START_TICKS = 17,
  parameter int BASE_EXP    = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                intTick,
  input  logic                hsTick,
  input  ctrlStrobe_t         strb,
  input  logic [SEL_W-1:0]    selIdx,
  output logic                stabDone,
  output logic [NUM_STAB-1:0] stabFlags,
  output logic                cpuTick
);
  localparam int START_W = $clog2(START_TICKS + 1);
  localparam int MAX_EXP = BASE_EXP + NUM_STAB;
  localparam int CNT_W   = MAX_EXP + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << MAX_EXP;

  // exponent ladder: base, then base+2, base+3, ...
  function automatic int stabExp(input int k);
    return (k == 0) ? BASE_EXP : BASE_EXP + 1 + k;
  endfunction

  logic [START_W-1:0] startCnt;
  logic               startDone;
  logic [CNT_W-1:0]   stabCnt;

  // startup hold-off on internal ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startCnt  <= '0;
      startDone <= 1'b0;
    end else if (!startDone && intTick && strb.intRun) begin
      if (startCnt == START_W'(START_TICKS - 1)) startDone <= 1'b1;
      else startCnt <= startCnt + 1'b1;
    end
  end

  // settling counter, saturating, cleared while the oscillator is off
  always_ff @(posedge clk) begin
    if (!rstN || !strb.hsRun) stabCnt <= '0;
    else if (hsTick && stabCnt != CNT_MAX) stabCnt <= stabCnt + 1'b1;
  end

  for (genvar k = 0; k < NUM_STAB; k++) begin : g_flag
    assign stabFlags[k] = (stabCnt >= (CNT_W'(1) << stabExp(k)));
  end

  assign stabDone = stabFlags[selIdx];

  always_comb begin
    cpuTick = 1'b0;
    if (rstN && startDone && !strb.cpuHold)
      cpuTick = strb.useHs ? (hsTick && stabDone) : (intTick && strb.intRun);
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              intTick,
  input  logic              hsTick,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stopEnter,
  input  logic              stopRelease,
  input  logic              stabDone,
  output ctrlStrobe_t       strb,
  output logic [SEL_W-1:0]  selIdx,
  output logic              srcIsHs,
  output logic              hsOscEn,
  output logic              intOscEn
);
  localparam logic CTRL_ADDR = 1'b0;
  localparam logic SEL_ADDR  = 1'b1;
  localparam int REQ_BIT    = 0;
  localparam int HSOFF_BIT  = 1;
  localparam int INTOFF_BIT = 2;

  logic selReq, hsOff, intOff, stopped, srcHs;
  logic idle;
  logic [SEL_W-1:0] selIn, selNext;

  assign idle    = !intTick && !hsTick;
  assign selIn   = wrData[SEL_W-1:0];
  assign selNext = (selIn >= SEL_W'(NUM_STAB)) ? SEL_W'(NUM_STAB - 1) : selIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReq  <= 1'b0;
      hsOff   <= 1'b0;
      intOff  <= 1'b0;
      selIdx  <= '0;
      stopped <= 1'b0;
      srcHs   <= 1'b0;
    end else begin
      if (wrEn && wrAddr == CTRL_ADDR) begin
        selReq <= wrData[REQ_BIT];
        hsOff  <= wrData[HSOFF_BIT]  ? (srcHs ? hsOff : 1'b1)  : 1'b0;
        intOff <= wrData[INTOFF_BIT] ? (srcHs ? 1'b1 : intOff) : 1'b0;
      end
      if (wrEn && wrAddr == SEL_ADDR) selIdx <= selNext;

      if (stopEnter) stopped <= 1'b1;
      else if (stopRelease) stopped <= 1'b0;

      if (idle) begin
        if (selReq && !srcHs && stabDone && !stopped) srcHs <= 1'b1;
        else if (!selReq && srcHs && !intOff) srcHs <= 1'b0;
      end
    end
  end

  assign hsOscEn  = rstN && !stopped && !hsOff;
  assign intOscEn = rstN && !stopped && !intOff;
  assign srcIsHs  = srcHs;

  always_comb begin
    strb.hsRun   = hsOscEn;
    strb.intRun  = intOscEn;
    strb.useHs   = srcHs;
    strb.cpuHold = stopped;
  end
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clksw_pkg::*;
#(
  parameter int START_TICKS = 17,
  parameter int BASE_EXP    = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                intTick,
  input  logic                hsTick,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                stopEnter,
  input  logic                stopRelease,
  output logic                cpuTick,
  output logic                srcIsHs,
  output logic [NUM_STAB-1:0] stabFlags,
  output logic                hsOscEn,
  output logic                intOscEn
);
  ctrlStrobe_t      strb;
  logic [SEL_W-1:0] selIdx;
  logic             stabDone;

  clksw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .intTick(intTick), .hsTick(hsTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stopEnter(stopEnter), .stopRelease(stopRelease), .stabDone(stabDone),
    .strb(strb), .selIdx(selIdx), .srcIsHs(srcIsHs),
    .hsOscEn(hsOscEn), .intOscEn(intOscEn)
  );

  clksw_datapath #(.START_TICKS(START_TICKS), .BASE_EXP(BASE_EXP)) dp_i (
    .clk(clk), .rstN(rstN), .intTick(intTick), .hsTick(hsTick),
    .strb(strb), .selIdx(selIdx), .stabDone(stabDone),
    .stabFlags(stabFlags), .cpuTick(cpuTick)
  );
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk #(
  parameter int START_TICKS = 17
) (
  input logic       clk,
  input logic       rstN,
  input logic       intTick,
  input logic       hsTick,
  input logic       cpuTick,
  input logic       srcIsHs,
  input logic [4:0] stabFlags,
  input logic       hsOscEn,
  input logic       intOscEn
);
  localparam int W = $clog2(START_TICKS + 1);
  logic [W-1:0] seenInt;

  always_ff @(posedge clk) begin
    if (!rstN) seenInt <= '0;
    else if (intTick && intOscEn && seenInt != W'(START_TICKS)) seenInt <= seenInt + 1'b1;
  end

  // R1
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!srcIsHs && stabFlags == 5'b0 && hsOscEn && intOscEn));

  // R2
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenInt < W'(START_TICKS)) |-> !cpuTick);

  // R5
  switch_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srcIsHs) |-> $past(stabFlags != 5'b0));

  // R6
  switch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcIsHs != $past(srcIsHs)) |-> (!$past(intTick) && !$past(hsTick)));

  // R8
  hs_off_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intOscEn && !hsOscEn) |-> !srcIsHs);

  // R8
  int_off_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsOscEn && !intOscEn) |-> srcIsHs);

  // R9
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hsOscEn && !intOscEn) |-> !cpuTick);
endmodule

bind clk_src_switch clk_src_switch_chk #(.START_TICKS(START_TICKS)) chk_i (
  .clk(clk), .rstN(rstN), .intTick(intTick), .hsTick(hsTick),
  .cpuTick(cpuTick), .srcIsHs(srcIsHs), .stabFlags(stabFlags),
  .hsOscEn(hsOscEn), .intOscEn(intOscEn)
);

// File: tb/clk_src_switch_tb_top.sv
module clk_src_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intTick = 1'b0, hsTick = 1'b0;
  logic wrEn = 1'b0, wrAddr = 1'b0;
  logic [2:0] wrData = '0;
  logic stopEnter = 1'b0, stopRelease = 1'b0;
  logic cpuTick, srcIsHs, hsOscEn, intOscEn;
  logic [4:0] stabFlags;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic obsCpu;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_switch dut_i (
    .clk(clk), .rstN(rstN), .intTick(intTick), .hsTick(hsTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stopEnter(stopEnter), .stopRelease(stopRelease),
    .cpuTick(cpuTick), .srcIsHs(srcIsHs), .stabFlags(stabFlags),
    .hsOscEn(hsOscEn), .intOscEn(intOscEn)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic i, input logic h);
    @(negedge clk);
    intTick = i; hsTick = h;
    #1 obsCpu = cpuTick;
  endtask

  task automatic regWrite(input logic a, input logic [2:0] d);
    @(negedge clk);
    intTick = 0; hsTick = 0;
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
    #1;
  endtask

  task automatic pulseStop(input bit enter);
    @(negedge clk);
    intTick = 0; hsTick = 0;
    stopEnter = enter; stopRelease = !enter;
    @(negedge clk);
    stopEnter = 0; stopRelease = 0;
    #1;
  endtask

  task automatic testReset();
    rstN = 0;
    step(1, 1);
    chk("R1", "hsOscEn in reset", hsOscEn, 0);
    chk("R1", "intOscEn in reset", intOscEn, 0);
    chk("R1", "cpuTick in reset", obsCpu, 0);
    step(0, 0);
    @(negedge clk); rstN = 1;
    #1;
    chk("R1", "srcIsHs after reset", srcIsHs, 0);
    chk("R1", "flags after reset", stabFlags, 0);
    chk("R1", "enables after reset", {hsOscEn, intOscEn}, 2'b11);
  endtask

  task automatic testStartup();
    int seen = 0;
    for (int n = 0; n < 17; n++) begin
      step(1, 0);
      if (obsCpu) seen++;
      step(0, 0);
    end
    chk("R2", "cpuTicks in first 17", seen, 0);
    step(1, 0);
    chk("R2", "18th internal tick", obsCpu, 1);
    step(0, 0);
    chk("R2", "no tick when idle", obsCpu, 0);
  endtask

  task automatic testSwitchCode0();
    regWrite(1'b0, 3'b001);
    for (int n = 0; n < 2047; n++) step(0, 1);
    step(0, 0);
    step(1, 0);
    chk("R5", "pending flags", stabFlags, 5'b00000);
    chk("R5", "pending srcIsHs", srcIsHs, 0);
    chk("R5", "pending cpuTick follows int", obsCpu, 1);
    step(0, 1);
    step(1, 0);
    chk("R3", "flag0 at 2^11", stabFlags, 5'b00001);
    step(0, 0);
    chk("R6", "no switch on busy edge", srcIsHs, 0);
    step(0, 1);
    chk("R6", "switched after idle edge", srcIsHs, 1);
    chk("R6", "cpuTick follows hs", obsCpu, 1);
    step(1, 0);
    chk("R6", "int tick ignored on hs", obsCpu, 0);
  endtask

  task automatic testOscStops();
    regWrite(1'b0, 3'b011);
    chk("R8", "hs stop ignored on hs", hsOscEn, 1);
    regWrite(1'b0, 3'b101);
    chk("R8", "int stop on hs", intOscEn, 0);
    regWrite(1'b0, 3'b100);
    step(0, 0); step(0, 0); step(0, 0);
    chk("R7", "return held while int off", srcIsHs, 1);
    regWrite(1'b0, 3'b000);
    step(0, 0);
    step(1, 0);
    chk("R7", "returned to internal", srcIsHs, 0);
    chk("R7", "cpuTick follows int", obsCpu, 1);
    chk("R7", "int osc running", intOscEn, 1);
    regWrite(1'b0, 3'b110);
    chk("R8", "int stop ignored on int", intOscEn, 1);
    chk("R8", "hs stop on int", hsOscEn, 0);
    step(0, 1);
    step(0, 0);
    chk("R8", "flags cleared by hs stop", stabFlags, 5'b00000);
    regWrite(1'b0, 3'b000);
    chk("R8", "hs restarted", hsOscEn, 1);
  endtask

  task automatic testCode7();
    regWrite(1'b1, 3'b111);
    regWrite(1'b0, 3'b001);
    for (int n = 0; n < 65535; n++) step(0, 1);
    step(0, 0);
    step(1, 0);
    chk("R4", "flags at 65535", stabFlags, 5'b01111);
    chk("R4", "code 7 waits for 2^16", srcIsHs, 0);
    step(0, 1);
    step(0, 0);
    chk("R3", "all flags at 2^16", stabFlags, 5'b11111);
    step(1, 0);
    chk("R4", "switched at 2^16", srcIsHs, 1);
    chk("R6", "int ignored on hs", obsCpu, 0);
  endtask

  task automatic testStop();
    int seen = 0;
    regWrite(1'b1, 3'b000);
    pulseStop(1);
    step(0, 1);
    chk("R9", "cpuTick in stop", obsCpu, 0);
    chk("R9", "enables in stop", {hsOscEn, intOscEn}, 2'b00);
    pulseStop(0);
    for (int n = 0; n < 2048; n++) begin
      step(0, 1);
      if (obsCpu) seen++;
    end
    chk("R9", "hs ticks held during resettle", seen, 0);
    step(0, 1);
    chk("R9", "hs tick after resettle", obsCpu, 1);
    regWrite(1'b0, 3'b000);
    step(0, 0);
    step(1, 0);
    chk("R7", "back on internal", srcIsHs, 0);
    pulseStop(1);
    step(1, 0);
    chk("R9", "int tick blocked in stop", obsCpu, 0);
    pulseStop(0);
    step(1, 0);
    chk("R9", "int resumes at once", obsCpu, 1);
  endtask

  initial begin
    testReset();
    testStartup();
    testSwitchCode0();
    testOscStops();
    testCode7();
    testStop();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule